// File: doc/BRIEF.md
# DRAM row glitch-clear sequencer

This block drives the row strobe, column strobe and multiplexed address pins of an asynchronous 64K x 1 DRAM. Its job is to force every one of the 256 cells in a single row to that row's stable level. It does this with a run of deliberately short row-strobe low pulses, each shorter than the sense amplifiers need to restore the cells, and then one ordinary row-only refresh of the same row. That refresh latches the wiped value. Rows with non-inverting cells end up holding 1, and rows with inverting cells end up holding 0. The pin sequence is the same in both cases.

A host starts an operation with a one-cycle strobe, together with an 8-bit row number and a 32-bit repeat count. The block first parks both strobes high and presents the row on the address bus for a setup window. It then issues the requested number of short low pulses on the row strobe, each followed by a precharge gap. After that it runs one full refresh cycle. While this happens the host sees `busy_o`, and it sees a single-cycle `done_o` when the closing precharge has elapsed. A repeat count of zero skips the pulses and goes straight to the refresh.

Top module: `dram_row_wipe_seq`

## Requirements
- R1: After a synchronous active-high reset, the row strobe and column strobe are high, and `busy_o` and `done_o` are low. A reset in the middle of an operation abandons it.
- R2: An accepted start latches `row_i` onto `addr_o`. The address stays unchanged until the operation ends. The column strobe stays high at all times.
- R3: For exactly SETUP_CYC (default 3) cycles after acceptance, the row strobe stays high with the address valid before the first falling edge.
- R4: Each wipe pulse holds the row strobe low for exactly GLITCH_CYC (default 2) cycles.
- R5: After each wipe pulse, the row strobe stays high for exactly PRE_CYC (default 3) cycles.
- R6: A repeat count N produces exactly N wipe pulses before the refresh. N = 0 produces none, and the refresh follows the setup window directly.
- R7: The closing refresh holds the row strobe low for RFSH_CYC (default 4) cycles and then high for PRE_CYC cycles.
- R8: `busy_o` is high from the cycle after acceptance through the end of the refresh precharge. In the next cycle `busy_o` is low and `done_o` is high for exactly one cycle.
- R9: A start strobe that arrives while `busy_o` is high is ignored. Its row and count have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start strobe, taken only when idle |
| row_i | input | 8 | Row to wipe |
| reps_i | input | 32 | Number of short row-strobe pulses |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low, held high |
| addr_o | output | 8 | Multiplexed DRAM address |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume the following about the inputs:
- `start_i` is a plain level sampled at the clock, so a start that overlaps the final busy cycle must be ignored.
- The phase lengths are at least one cycle.
- The exact two-cycle pulse check relies on the default pulse width.

The stimulus keeps repeat counts small enough for short runs, except for one longer burst. It changes inputs only a short time after the rising edge. It also deliberately raises start with a different row and count in the middle of an operation, to exercise R9 against these assumptions.

// File: rtl/dram_wipe_pkg.sv
package dram_wipe_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_GLOW,
    PH_GPRE,
    PH_RLOW,
    PH_RPRE
  } phase_e;

  // Length in cycles of a given phase; idle counts as a single cycle.
  function automatic int unsigned phase_cycles(phase_e p, int unsigned setup_c,
                                               int unsigned glitch_c, int unsigned pre_c,
                                               int unsigned rfsh_c);
    case (p)
      PH_SETUP: return setup_c;
      PH_GLOW:  return glitch_c;
      PH_GPRE:  return pre_c;
      PH_RLOW:  return rfsh_c;
      PH_RPRE:  return pre_c;
      default:  return 1;
    endcase
  endfunction

  function automatic int unsigned max4(int unsigned a, int unsigned b,
                                       int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/wipe_phase_timer.sv
module wipe_phase_timer #(
  parameter int TMR_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [TMR_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load_i)      cnt_q <= load_val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/wipe_rep_tracker.sv
module wipe_rep_tracker #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             is_zero_o,
  output logic             is_one_o
);
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst)                        left_q <= '0;
    else if (load_i)                left_q <= load_val_i;
    else if (dec_i && left_q != '0) left_q <= left_q - 1'b1;
  end

  assign is_zero_o = (left_q == '0);
  assign is_one_o  = (left_q == CNT_W'(1));
endmodule

// File: rtl/dram_row_wipe_seq.sv
module dram_row_wipe_seq
  import dram_wipe_pkg::*;
#(
  parameter int ROW_W      = 8,
  parameter int CNT_W      = 32,
  parameter int SETUP_CYC  = 3,
  parameter int GLITCH_CYC = 2,
  parameter int PRE_CYC    = 3,
  parameter int RFSH_CYC   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [CNT_W-1:0] reps_i,
  output logic             ras_n_o,
  output logic             cas_n_o,
  output logic [ROW_W-1:0] addr_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int unsigned MAX_CYC = max4(SETUP_CYC, GLITCH_CYC, PRE_CYC, RFSH_CYC);
  localparam int TMR_W = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  phase_e           phase_q, phase_d;
  logic [ROW_W-1:0] addr_q;
  logic             done_q;

  // Named internal events
  logic accept_w, step_w, glitch_end_w, loop_exit_w, op_end_w;
  logic tmr_zero, reps_zero, reps_one, rep_dec;
  logic tmr_load;
  logic [TMR_W-1:0] tmr_val;

  assign accept_w     = (phase_q == PH_IDLE) && start_i;
  assign step_w       = (phase_q != PH_IDLE) && tmr_zero;
  assign glitch_end_w = (phase_q == PH_GLOW) && step_w;
  assign loop_exit_w  = (phase_q == PH_GPRE) && step_w && reps_one;
  assign op_end_w     = (phase_q == PH_RPRE) && step_w;
  assign rep_dec      = (phase_q == PH_GPRE) && step_w;

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE:  if (start_i) phase_d = PH_SETUP;
      PH_SETUP: if (step_w)  phase_d = reps_zero ? PH_RLOW : PH_GLOW;
      PH_GLOW:  if (step_w)  phase_d = PH_GPRE;
      PH_GPRE:  if (step_w)  phase_d = reps_one ? PH_RLOW : PH_GLOW;
      PH_RLOW:  if (step_w)  phase_d = PH_RPRE;
      PH_RPRE:  if (step_w)  phase_d = PH_IDLE;
      default:               phase_d = PH_IDLE;
    endcase
  end

  assign tmr_load = (phase_d != phase_q);
  assign tmr_val  = TMR_W'(phase_cycles(phase_d, SETUP_CYC, GLITCH_CYC, PRE_CYC, RFSH_CYC) - 1);

  wipe_phase_timer #(.TMR_W(TMR_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  wipe_rep_tracker #(.CNT_W(CNT_W)) u_reps (
    .clk        (clk),
    .rst        (rst),
    .load_i     (accept_w),
    .load_val_i (reps_i),
    .dec_i      (rep_dec),
    .is_zero_o  (reps_zero),
    .is_one_o   (reps_one)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      addr_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= op_end_w;
      if (accept_w) addr_q <= row_i;
    end
  end

  assign ras_n_o = !((phase_q == PH_GLOW) || (phase_q == PH_RLOW));
  assign cas_n_o = 1'b1;
  assign addr_o  = addr_q;
  assign busy_o  = (phase_q != PH_IDLE);
  assign done_o  = done_q;

  // ---------------- assertions ----------------
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    busy_o && $past(busy_o) |-> $stable(addr_o)); // R2

  AST_SETUP_HIGH: assert property (@(posedge clk) disable iff (rst)
    $past(accept_w) |-> ras_n_o && busy_o); // R3

  generate
    if (GLITCH_CYC == 2) begin : g_two_cycle_check
      AST_GLITCH_WIDTH: assert property (@(posedge clk) disable iff (rst)
        glitch_end_w |-> !$past(ras_n_o) && $past(ras_n_o, 2)); // R4
    end
  endgenerate

  AST_PRE_AFTER_GLITCH: assert property (@(posedge clk) disable iff (rst)
    glitch_end_w |=> ras_n_o); // R5

  AST_ZERO_SKIPS: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_SETUP) && step_w && reps_zero |=> !ras_n_o && (phase_q == PH_RLOW)); // R6

  AST_LOOP_TO_RFSH: assert property (@(posedge clk) disable iff (rst)
    loop_exit_w |=> !ras_n_o && (phase_q == PH_RLOW)); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R8

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o && $past(busy_o)); // R8

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    busy_o && start_i && !op_end_w |=> busy_o && $stable(addr_o)); // R9

endmodule

// File: tb/dram_row_wipe_seq_tb.sv
module dram_row_wipe_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [7:0]  row_i = '0;
  logic [31:0] reps_i = '0;
  logic        ras_n_o, cas_n_o, busy_o, done_o;
  logic [7:0]  addr_o;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic  ras;
    logic  busy;
    logic  done;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  logic [7:0] exp_row = '0;
  int exp_reps = 0;
  int falls = 0;
  logic prev_ras = 1'b1;

  always #4 clk = ~clk; // 125 MHz

  dram_row_wipe_seq dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .row_i(row_i), .reps_i(reps_i),
    .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .addr_o(addr_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  task automatic push_n(int n, logic r, logic b, logic d, string t);
    for (int i = 0; i < n; i++) exp_q.push_back('{ras: r, busy: b, done: d, tag: t});
  endtask

  // Behavioural expectation for a full operation
  task automatic plan_op(int n);
    push_n(3, 1'b1, 1'b1, 1'b0, "R3");
    for (int i = 0; i < n; i++) begin
      push_n(2, 1'b0, 1'b1, 1'b0, "R4");
      push_n(3, 1'b1, 1'b1, 1'b0, "R5");
    end
    push_n(4, 1'b0, 1'b1, 1'b0, (n == 0) ? "R6" : "R7");
    push_n(3, 1'b1, 1'b1, 1'b0, "R7");
    push_n(1, 1'b1, 1'b0, 1'b1, "R8");
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] expv, string what);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, expv, $time);
    end
  endtask

  // Reference comparison every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst) begin
      exp_q.delete();
      falls = 0;
      prev_ras = 1'b1;
    end else begin
      exp_t e;
      if (exp_q.size() > 0) e = exp_q.pop_front();
      else e = '{ras: 1'b1, busy: 1'b0, done: 1'b0, tag: "R1"};
      check(e.tag, 32'(ras_n_o), 32'(e.ras), "ras_n");
      check(e.tag, 32'(busy_o), 32'(e.busy), "busy");
      check(e.tag, 32'(done_o), 32'(e.done), "done");
      check("R2", 32'(cas_n_o), 32'd1, "cas_n");
      if (e.busy) check("R9", 32'(addr_o), 32'(exp_row), "addr (R2 hold)");
      if (prev_ras && !ras_n_o) falls++;
      prev_ras = ras_n_o;
      if (e.done) begin
        check("R6", 32'(falls), 32'(exp_reps + 1), "row strobe falls");
        falls = 0;
      end
      if (start_i && exp_q.size() == 0) begin
        exp_row  = row_i;
        exp_reps = int'(reps_i);
        plan_op(exp_reps);
      end
    end
  end

  // Caller must be at posedge + 2
  task automatic launch(logic [7:0] r, int n);
    start_i = 1'b1; row_i = r; reps_i = 32'(n);
    @(posedge clk); #2;
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    do begin
      @(posedge clk); #2;
    end while (!done_o);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1", 32'({ras_n_o, cas_n_o, busy_o, done_o}), 32'b1100, "reset state");
    rst = 1'b0;
    @(posedge clk); #2;

    launch(8'h00, 1); wait_done();          // non-inverting row example
    @(posedge clk); #2;
    launch(8'h40, 0); wait_done();          // R6 zero count
    launch(8'h7F, 2); wait_done();          // back-to-back start on done cycle
    @(posedge clk); #2;

    launch(8'hFF, 5);                       // R9: start while busy is ignored
    repeat (6) @(posedge clk);
    #2;
    start_i = 1'b1; row_i = 8'hAA; reps_i = 32'd9;
    @(posedge clk); #2;
    start_i = 1'b0;
    wait_done();
    @(posedge clk); #2;

    launch(8'h12, 3);                       // R1: reset mid operation
    repeat (6) @(posedge clk);
    #2;
    rst = 1'b1;
    @(posedge clk); #2;
    check("R1", 32'({ras_n_o, cas_n_o, busy_o, done_o}), 32'b1100, "state after mid-op reset");
    rst = 1'b0;
    @(posedge clk); #2;

    launch(8'h33, 40); wait_done();         // long burst
    repeat (4) @(posedge clk);
    #2;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule